// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a differential successive-approximation converter. A one-cycle start request ends the sampling window and begins a binary search. The search decides one bit of the trial code per clock, starting at the most significant bit. Each step sets the bit under test and reads the comparator. The comparator reports whether the held differential sample lies at or above the level that the current trial code represents. The bit is kept when the comparator reports high and cleared when it reports low.

The trial code drives the switch array of the capacitive DAC. It is in offset-binary form. When the last bit has been decided, the block inverts the top bit of the offset-binary code to form a two's-complement result. It latches that result, raises a one-cycle done strobe and returns to an idle state with the trial code at zero. The result belongs to the sample just taken, so there is no pipeline delay. Inputs beyond either end of the range produce saturated codes with no extra logic, because the search cannot go past all-ones or all-zeros.

Top module: `sar_sequencer`

## Requirements
- R1: While reset is held and after it is released, busy and done are 0, the trial code is 0 and the result is 0.
- R2: A start request sampled while idle sets busy in the next cycle, and the trial code becomes a lone set MSB (0x8000 for 16 bits).
- R3: In each busy cycle, the bits above the bit under test hold their decided values, the bit under test is 1 and the bits below it are 0. The bit under test moves one place toward the LSB per clock.
- R4: Busy stays high for exactly DATA_W cycles (16 at the default). Done is a single-cycle pulse in the cycle that follows the last busy cycle, and busy is 0 in that cycle.
- R5: The result is the offset-binary search outcome with its MSB inverted. Zero differential input gives 0x0000, +1 LSB gives 0x0001 and −1 LSB gives 0xFFFF.
- R6: A sample at or above +32767 LSB yields 0x7FFF. A sample below −32768 LSB yields 0x8000.
- R7: A start request that arrives while busy has no effect. The running conversion keeps its length and its result.
- R8: The result holds its value until the next done pulse. Outside a conversion the trial code is 0.
- R9: A comparator input of 1 keeps the bit under test and 0 clears it. The comparator reports 1 when the sample is at or above (trial code − 2^(DATA_W−1)) LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, one decision per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | One-cycle start of conversion; sampling ends here |
| cmpKeep | input | 1 | Comparator decision for the current trial code |
| trialCode | output | 16 | Offset-binary trial code to the DAC switches |
| busy | output | 1 | High while a conversion runs |
| doneP | output | 1 | One-cycle pulse when the result is updated |
| resultCode | output | 16 | Two's-complement result of the last conversion |

## Verification
The bench builds the block at its default width of 16 bits. At that width the exact codes 0x7FFF, 0x8000, 0x0001 and 0xFFFF can be checked directly, as can samples beyond both ends of the range. The bench's ideal comparator and behavioural model follow all 16 decisions of the search. This covers keeping or clearing every bit position, and a stray start request in the middle of a conversion.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;
  typedef struct packed {
    logic load;
    logic step;
    logic last;
  } seqStrobe_t;
endpackage

// File: rtl/sarseq_ctrl.sv
module sarseq_ctrl
  import sarseq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  output logic       busy,
  output seqStrobe_t strb
);
  localparam int CW = $clog2(DATA_W);
  localparam logic [CW-1:0] TOP_IDX = CW'(DATA_W - 1);

  logic [CW-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      bitCnt <= '0;
    end else if (!busy) begin
      if (startReq) begin
        busy   <= 1'b1;
        bitCnt <= TOP_IDX;
      end
    end else if (bitCnt == '0) begin
      busy <= 1'b0;
    end else begin
      bitCnt <= bitCnt - 1'b1;
    end
  end

  always_comb begin
    strb.load = startReq & ~busy;
    strb.step = busy;
    strb.last = busy & (bitCnt == '0);
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> (busy && bitCnt == TOP_IDX));
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && bitCnt != '0) |=> (busy && bitCnt == $past(bitCnt) - 1'b1));
  // R4
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && bitCnt == '0) |=> !busy);
endmodule

// File: rtl/sarseq_datapath.sv
module sarseq_datapath
  import sarseq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic              cmpKeep,
  output logic [DATA_W-1:0] trialCode,
  output logic [DATA_W-1:0] resultCode,
  output logic              doneP
);
  localparam logic [DATA_W-1:0] MSB_ONLY = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] trialReg;
  logic [DATA_W-1:0] ptrMask;
  logic [DATA_W-1:0] decided;

  for (genvar i = 0; i < DATA_W; i++) begin : g_decide
    assign decided[i] = ptrMask[i] ? cmpKeep : trialReg[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trialReg   <= '0;
      ptrMask    <= '0;
      resultCode <= '0;
      doneP      <= 1'b0;
    end else begin
      doneP <= 1'b0;
      if (strb.load) begin
        trialReg <= MSB_ONLY;
        ptrMask  <= MSB_ONLY;
      end else if (strb.last) begin
        resultCode <= decided ^ MSB_ONLY;
        trialReg   <= '0;
        ptrMask    <= '0;
        doneP      <= 1'b1;
      end else if (strb.step) begin
        trialReg <= decided | (ptrMask >> 1);
        ptrMask  <= ptrMask >> 1;
      end
    end
  end

  assign trialCode = trialReg;

  // R3
  ptr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ptrMask));
  // R3
  trial_bit_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> ((trialReg & ptrMask) == ptrMask && ptrMask != '0));
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.last |=> $stable(resultCode));
  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP);
  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.step && !strb.load) |=> (trialCode == '0 || $past(trialCode) != '0));
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sarseq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              cmpKeep,
  output logic [DATA_W-1:0] trialCode,
  output logic              busy,
  output logic              doneP,
  output logic [DATA_W-1:0] resultCode
);
  seqStrobe_t strb;

  sarseq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .busy     (busy),
    .strb     (strb)
  );

  sarseq_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cmpKeep    (cmpKeep),
    .trialCode  (trialCode),
    .resultCode (resultCode),
    .doneP      (doneP)
  );

  // R4
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneP |-> !busy);
endmodule

// File: tb/sar_sequencer_tb.sv
module sar_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int HALF = 1 << (W - 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic cmpKeep;
  logic [W-1:0] trialCode;
  logic busy;
  logic doneP;
  logic [W-1:0] resultCode;

  int sampleVal = 0;
  int nVec = 0;
  int nBad = 0;
  int cyc = 0;

  int mBusy = 0, mIdx = 0, mTrial = 0, mResult = 0, mDone = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // ideal comparator (R9)
  always_comb cmpKeep = (sampleVal >= int'(trialCode) - HALF);

  sar_sequencer #(.DATA_W(W)) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmpKeep(cmpKeep),
    .trialCode(trialCode), .busy(busy), .doneP(doneP), .resultCode(resultCode)
  );

  // behavioural reference model
  always @(posedge clk or negedge rstN) begin
    cyc++;
    if (!rstN) begin
      mBusy = 0; mIdx = 0; mTrial = 0; mResult = 0; mDone = 0;
    end else if (mBusy != 0) begin
      if (!(sampleVal >= mTrial - HALF)) mTrial -= (1 << mIdx);
      if (mIdx == 0) begin
        mResult = (mTrial ^ HALF) & ((1 << W) - 1);
        mDone = 1; mBusy = 0; mTrial = 0;
      end else begin
        mTrial += (1 << (mIdx - 1));
        mIdx--;
        mDone = 0;
      end
    end else begin
      mDone = 0;
      if (startReq) begin
        mBusy = 1; mIdx = W - 1; mTrial = HALF;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rstN) begin
      chk("R4 busy", int'(busy), mBusy);
      chk("R4 done", int'(doneP), mDone);
      chk("R3 trial", int'(trialCode), mTrial);
      chk("R5 result", int'(resultCode), mResult);
    end
  end

  function automatic int expCode(input int s);
    int c;
    c = s;
    if (c > HALF - 1) c = HALF - 1;
    if (c < -HALF) c = -HALF;
    return c & ((1 << W) - 1);
  endfunction

  task automatic convert(input int s, input string req, input bit stray);
    int busyCnt;
    sampleVal = s;
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    chk("R2 trial after start", int'(trialCode), HALF);
    busyCnt = 0;
    for (int k = 0; k < 40 && !doneP; k++) begin
      if (busy) busyCnt++;
      if (stray && k == 5) startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
    end
    chk("R4 busy length", busyCnt, W);
    chk("R4 done seen", int'(doneP), 1);
    chk(req, int'(resultCode), expCode(s));
    @(negedge clk);
    chk("R4 done single", int'(doneP), 0);
    chk("R8 trial idle", int'(trialCode), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(doneP), 0);
    chk("R1 trial", int'(trialCode), 0);
    chk("R1 result", int'(resultCode), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'(resultCode), 0);

    convert(0, "R5 midscale", 0);
    convert(1, "R5 plus one", 0);
    convert(-1, "R5 minus one", 0);
    convert(12345, "R9 positive", 0);
    convert(-20000, "R9 negative", 0);
    convert(21845, "R9 alternating", 0);
    convert(32767, "R6 top code", 0);
    convert(40000, "R6 over range", 0);
    convert(-32768, "R6 bottom code", 0);
    convert(-40000, "R6 under range", 0);
    convert(-1234, "R7 stray start", 1);

    // R8: result holds while idle
    repeat (10) @(negedge clk);
    chk("R8 result hold", int'(resultCode), expCode(-1234));
    chk("R8 still idle", int'(busy), 0);

    for (int n = 0; n < 20; n++) convert((n * 7919 % 70000) - 35000, "R5 sweep", 0);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nBad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule